// File: doc/BRIEF.md
# I2C SCL Clock Divider

This block produces the SCL timing for an I2C master from the system clock. Two 8-bit configuration bytes supply a 12-bit divider value and a speed-mode select. From these the block works out how many system clocks the SCL line spends low and high in each bit period. It tells the byte engine when to pull SCL low and when to release it. It also gives the byte engine a strobe at the start of each low phase and a strobe in the middle of each high phase, where data is sampled.

The low configuration byte holds the seven least significant divider bits and, in its top bit, the mode select. The high configuration byte holds the five most significant divider bits. In standard mode the high and low phases differ by one clock. In fast mode the low phase is exactly twice the high phase. A slave can stretch the clock: while the block has released SCL but the line still reads low, the high-phase count is held. A divider value below 2 is rejected. The block then stops once the current period is over, leaves SCL released, and raises a status flag. Configuration changes are picked up only at a period boundary, so a bit period is never built from a mix of old and new settings.

Top module: `scl_clk_div`

## Requirements
- R1: The divider CC is {div_hi_cfg[4:0], div_lo_cfg[6:0]}; CC bit 7 comes from div_hi_cfg bit 0, and div_hi_cfg[7:5] have no effect on timing or on cfg_bad.
- R2: div_lo_cfg bit 7 = 1 selects fast mode and 0 selects standard mode.
- R3: In standard mode each period has CC+3 low cycles (scl_low_en = 1) and CC+2 high cycles (scl_high_en = 1), so the period is 2*(CC-1)+7 clocks.
- R4: In fast mode each period has 2*CC+4 low cycles and CC+2 high cycles, so the period is 3*(CC-1)+9 clocks.
- R5: When CC < 2, cfg_bad is 1 from the clock edge after the value is applied. Once the current period is over, scl_low_en and scl_high_en both stay 0 until a legal value is applied. After that, cfg_bad returns to 0 and periods start again.
- R6: In the high phase, every cycle in which scl_in reads 0 holds the count, which lengthens the high phase by one cycle. No sample strobe is issued during the hold.
- R7: A change to either configuration byte takes effect at the start of the next period. The period in progress completes with its old lengths.
- R8: scl_fall_stb pulses exactly once per period, in the first low cycle. scl_sample_stb pulses exactly once per period, inside the high phase.
- R9: While rst_n is 0, scl_low_en, scl_high_en, scl_fall_stb, scl_sample_stb and cfg_bad are all 0.
- R10: scl_low_en and scl_high_en are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_lo_cfg | input | 8 | Mode select (bit 7) and divider bits 6:0 |
| div_hi_cfg | input | 8 | Divider bits 11:7 in bits 4:0; bits 7:5 unused |
| scl_in | input | 1 | Synchronized level of the SCL line |
| scl_low_en | output | 1 | SCL is to be driven low this cycle |
| scl_high_en | output | 1 | SCL is released this cycle (high phase) |
| scl_fall_stb | output | 1 | First cycle of a low phase |
| scl_sample_stb | output | 1 | Mid-high sampling point for the byte engine |
| cfg_bad | output | 1 | Divider value below 2 is applied |

## Verification
The bench builds the block with its default widths: 8-bit configuration bytes, with the divider split into seven low bits and five high bits. This brings the whole 12-bit divider range within reach. That includes the largest value, 4095, whose standard period is over eight thousand clocks, and a value of 128 that exercises the bit carried in the high byte. With SCL looped back, phase lengths are measured on whole periods in both modes. Clock stretching is applied for a known number of cycles. Configuration changes are made mid-period, and illegal values are tried, including one whose unused high-byte bits are set.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;

    // Smallest divider value that yields a usable period
    localparam int unsigned MIN_DIV = 2;

    // Phase length offsets over the divider value
    localparam int unsigned STD_LOW_ADD  = 3;
    localparam int unsigned FAST_LOW_ADD = 4;
    localparam int unsigned HIGH_ADD     = 2;

endpackage

// File: rtl/scl_cfg_decode.sv
module scl_cfg_decode
    import scl_div_pkg::*;
#(
    parameter int REG_W   = 8,
    parameter int CC_LO_W = 7,
    parameter int CC_HI_W = 5,
    parameter int CNT_W   = CC_LO_W + CC_HI_W + 2
) (
    input  logic [REG_W-1:0] lo_cfg,
    input  logic [REG_W-1:0] hi_cfg,
    output logic             legal,
    output logic [CNT_W-1:0] low_len,
    output logic [CNT_W-1:0] high_len
);
    localparam int CC_W     = CC_LO_W + CC_HI_W;
    localparam int MODE_BIT = REG_W - 1;

    logic [CC_W-1:0]  cc;
    logic [CNT_W-1:0] cc_x;
    logic             fast;

    always_comb begin
        cc       = {hi_cfg[CC_HI_W-1:0], lo_cfg[CC_LO_W-1:0]};
        fast     = lo_cfg[MODE_BIT];
        cc_x     = CNT_W'(cc);
        legal    = (cc_x >= CNT_W'(MIN_DIV));
        high_len = cc_x + CNT_W'(HIGH_ADD);
        if (fast) begin
            low_len = (cc_x << 1) + CNT_W'(FAST_LOW_ADD);
        end else begin
            low_len = cc_x + CNT_W'(STD_LOW_ADD);
        end
    end

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
    import scl_div_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_legal,
    input  logic [CNT_W-1:0] cfg_low_len,
    input  logic [CNT_W-1:0] cfg_high_len,
    input  logic             scl_in,
    output logic             low_en,
    output logic             high_en,
    output logic             fall_stb,
    output logic             sample_stb,
    output logic             bad
);
    typedef struct packed {
        scl_phase_e       ph;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] low_len;
        logic [CNT_W-1:0] high_len;
        logic             bad;
    } gen_state_t;

    gen_state_t st_d, st_q;

    logic low_last;
    logic high_last;

    always_comb begin
        st_d      = st_q;
        st_d.bad  = ~cfg_legal;
        low_last  = (st_q.cnt == st_q.low_len - CNT_W'(1));
        high_last = (st_q.cnt == st_q.high_len - CNT_W'(1));
        case (st_q.ph)
            PH_IDLE: begin
                if (cfg_legal) begin
                    st_d.ph       = PH_LOW;
                    st_d.cnt      = '0;
                    st_d.low_len  = cfg_low_len;
                    st_d.high_len = cfg_high_len;
                end
            end
            PH_LOW: begin
                if (low_last) begin
                    st_d.ph  = PH_HIGH;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_HIGH: begin
                if (!scl_in) begin
                    st_d.cnt = st_q.cnt;
                end else if (high_last) begin
                    st_d.cnt = '0;
                    if (cfg_legal) begin
                        st_d.ph       = PH_LOW;
                        st_d.low_len  = cfg_low_len;
                        st_d.high_len = cfg_high_len;
                    end else begin
                        st_d.ph = PH_IDLE;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            default: begin
                st_d.ph  = PH_IDLE;
                st_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cnt: '0, low_len: '0, high_len: '0, bad: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign low_en     = (st_q.ph == PH_LOW);
    assign high_en    = (st_q.ph == PH_HIGH);
    assign fall_stb   = (st_q.ph == PH_LOW) && (st_q.cnt == '0);
    assign sample_stb = (st_q.ph == PH_HIGH) && scl_in &&
                        (st_q.cnt == (st_q.high_len >> 1));
    assign bad        = st_q.bad;

    // R6
    hold_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_HIGH && !scl_in) |=> (st_q.ph == PH_HIGH && $stable(st_q.cnt)));

    // R5
    idle_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_IDLE && !cfg_legal) |=> (st_q.ph == PH_IDLE));

    // R7
    len_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_LOW && !low_last) |=> ($stable(st_q.low_len) && $stable(st_q.high_len)));

    // R10
    onehot_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({low_en, high_en}));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_HIGH) |-> (st_q.cnt < st_q.high_len));

endmodule

// File: rtl/scl_clk_div.sv
module scl_clk_div
    import scl_div_pkg::*;
#(
    parameter int REG_W   = 8,
    parameter int CC_LO_W = 7,
    parameter int CC_HI_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] div_lo_cfg,
    input  logic [REG_W-1:0] div_hi_cfg,
    input  logic             scl_in,
    output logic             scl_low_en,
    output logic             scl_high_en,
    output logic             scl_fall_stb,
    output logic             scl_sample_stb,
    output logic             cfg_bad
);
    localparam int CNT_W = CC_LO_W + CC_HI_W + 2;

    logic             legal;
    logic [CNT_W-1:0] low_len;
    logic [CNT_W-1:0] high_len;

    scl_cfg_decode #(
        .REG_W  (REG_W),
        .CC_LO_W(CC_LO_W),
        .CC_HI_W(CC_HI_W),
        .CNT_W  (CNT_W)
    ) u_dec (
        .lo_cfg  (div_lo_cfg),
        .hi_cfg  (div_hi_cfg),
        .legal   (legal),
        .low_len (low_len),
        .high_len(high_len)
    );

    scl_phase_gen #(
        .CNT_W(CNT_W)
    ) u_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_legal   (legal),
        .cfg_low_len (low_len),
        .cfg_high_len(high_len),
        .scl_in      (scl_in),
        .low_en      (scl_low_en),
        .high_en     (scl_high_en),
        .fall_stb    (scl_fall_stb),
        .sample_stb  (scl_sample_stb),
        .bad         (cfg_bad)
    );

endmodule

// File: tb/sim_scl_clk_div.sv
module sim_scl_clk_div;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] lo_cfg = 8'h02;
    logic [7:0] hi_cfg = 8'h00;
    logic       hold = 1'b0;
    logic       scl_in;
    logic       low_en, high_en, fall_stb, samp_stb, bad;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    // Open-drain loopback with an optional slave stretch
    assign scl_in = ~low_en & ~hold;

    scl_clk_div u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .div_lo_cfg    (lo_cfg),
        .div_hi_cfg    (hi_cfg),
        .scl_in        (scl_in),
        .scl_low_en    (low_en),
        .scl_high_en   (high_en),
        .scl_fall_stb  (fall_stb),
        .scl_sample_stb(samp_stb),
        .cfg_bad       (bad)
    );

    typedef struct packed {
        logic [7:0]  lo;
        logic [7:0]  hi;
        int unsigned nl;
        int unsigned nh;
    } vec_t;

    // Standard: low CC+3, high CC+2 (R3). Fast: low 2CC+4, high CC+2 (R4).
    // Field split and unused high bits (R1), mode bit (R2).
    localparam vec_t VECS [7] = '{
        '{8'h02, 8'h00, 5,    4},
        '{8'h03, 8'hE0, 6,    5},
        '{8'h83, 8'h00, 10,   5},
        '{8'h00, 8'h01, 131,  130},
        '{8'h85, 8'h01, 270,  135},
        '{8'h7F, 8'h1F, 4098, 4097},
        '{8'h82, 8'h00, 8,    4}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic measure(input bit wait_start, input int stretch,
                           output int nl, output int nh, output int nf, output int ns);
        int  left;
        bit  first;
        nl = 0; nh = 0; nf = 0; ns = 0; left = 0; first = 1'b1;
        if (wait_start) begin
            while (low_en) @(negedge clk);
            while (!low_en) @(negedge clk);
        end
        while (low_en) begin
            nl++;
            nf += int'(fall_stb);
            ns += int'(samp_stb);
            @(negedge clk);
        end
        while (high_en) begin
            nh++;
            nf += int'(fall_stb);
            ns += int'(samp_stb);
            if (first && stretch > 0) begin
                hold = 1'b1;
                left = stretch;
            end else if (left > 0) begin
                left--;
                if (left == 0) hold = 1'b0;
            end
            first = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int nl, nh, nf, ns, seen;

        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9 low_en", int'(low_en), 0);
        chk("R9 high_en", int'(high_en), 0);
        chk("R9 fall_stb", int'(fall_stb), 0);
        chk("R9 sample_stb", int'(samp_stb), 0);
        chk("R9 cfg_bad", int'(bad), 0);
        rst_n = 1'b1;

        // Vector walk: R1 R2 R3 R4 R8
        foreach (VECS[i]) begin
            lo_cfg = VECS[i].lo;
            hi_cfg = VECS[i].hi;
            measure(1'b1, 0, nl, nh, nf, ns);
            chk($sformatf("R3/R4 low vec%0d", i), nl, int'(VECS[i].nl));
            chk($sformatf("R3/R4 high vec%0d", i), nh, int'(VECS[i].nh));
            chk($sformatf("R8 fall count vec%0d", i), nf, 1);
            chk($sformatf("R8 sample count vec%0d", i), ns, 1);
            chk($sformatf("R1 cfg_bad vec%0d", i), int'(bad), 0);
        end

        // R6: stretch of 6 cycles on standard CC=5 (high 7 -> 13)
        lo_cfg = 8'h05; hi_cfg = 8'h00;
        measure(1'b1, 0, nl, nh, nf, ns);
        measure(1'b0, 6, nl, nh, nf, ns);
        chk("R6 stretched low", nl, 8);
        chk("R6 stretched high", nh, 13);
        chk("R6 sample once", ns, 1);

        // R7: change at period start applies to the following period
        lo_cfg = 8'h02;
        measure(1'b1, 0, nl, nh, nf, ns);
        lo_cfg = 8'h05;
        measure(1'b0, 0, nl, nh, nf, ns);
        chk("R7 old low kept", nl, 5);
        chk("R7 old high kept", nh, 4);
        measure(1'b0, 0, nl, nh, nf, ns);
        chk("R7 new low", nl, 8);
        chk("R7 new high", nh, 7);

        // R5: illegal CC=1 standard
        lo_cfg = 8'h01;
        @(negedge clk);
        chk("R5 cfg_bad set", int'(bad), 1);
        while (low_en || high_en) @(negedge clk);
        seen = 0;
        for (int k = 0; k < 100; k++) begin
            seen += int'(low_en) + int'(high_en);
            @(negedge clk);
        end
        chk("R5 idle phases", seen, 0);

        // R5 with R2: fast CC=0
        lo_cfg = 8'h80;
        @(negedge clk);
        chk("R5 fast zero bad", int'(bad), 1);
        // R1: unused high bits do not make CC=1 legal
        lo_cfg = 8'h81; hi_cfg = 8'hE0;
        repeat (2) @(negedge clk);
        chk("R1 unused bits bad", int'(bad), 1);
        chk("R1 unused bits idle", int'(low_en), 0);

        // R5 recovery
        lo_cfg = 8'h02; hi_cfg = 8'h00;
        @(negedge clk);
        chk("R5 cfg_bad clear", int'(bad), 0);
        chk("R5 restart low", int'(low_en), 1);
        measure(1'b0, 0, nl, nh, nf, ns);
        chk("R5 restart low len", nl, 5);
        chk("R5 restart high len", nh, 4);

        done = 1'b1;
        finish_run();
    end

endmodule